// File: doc/BRIEF.md
# Accumulator Normalizer with Index Count

This block normalizes a ones-complement accumulator held in a 24-bit primary register (AC) or in the 47-bit combined word formed by AC and the magnitude bits of a secondary register (BR). It also keeps an index value in step with the shift. A left normalize shifts toward the sign end until the sign bit and the bit below it differ, or until a fixed step limit is reached. The number of steps is then subtracted from the index value. A right normalize moves the word one place toward the low end, keeps the sign, and adds one to the index. It does this only when the overflow flag is set.

The surrounding datapath asserts `start` for one clock. With that strobe it presents the operation, the index register number, the overflow flag, and the current AC, BR and index values. The block takes all of these on the `start` edge and uses one clock per shift step. It then pulses `done`. The results stay on the outputs until the next accepted `start`. Index register numbers 6 and 7 turn any operation into a no-op.

Top module: `acc_normalizer`

## Requirements
- R1: While `rstN` is low and after it is released, `done` is 0 and `acOut`, `brOut` and `xrOut` are 0.
- R2: On a rising edge where the block is idle and `start` is 1, the block captures `op`, `xSel`, `ovfFlag`, `acIn`, `brIn` and `xrIn`. Later changes on these inputs do not affect the running operation.
- R3: When the captured `xSel` is 6 or 7, the block changes none of AC, BR or the index for any `op`, and it still pulses `done`.
- R4: Left normalize is selected when `op[0]`=0. Each step leaves the sign bit unchanged, moves every other bit one place toward the sign end, and puts the old sign into the lowest bit. Stepping stops as soon as the sign bit differs from the bit directly below it. A word that already meets this condition takes zero steps.
- R5: Left normalize takes at most 23 steps in AC-only mode and at most 46 steps in combined mode. A word that never meets the stop condition comes out after exactly that many steps.
- R6: When a left normalize ends, the index becomes index minus the step count. The subtraction is 16-bit ones-complement: the index is added to the inverted count and the carry out is added back in. Zero steps turn an index of 0 into 16'hFFFF.
- R7: Right normalize is selected when `op[0]`=1. When the captured flag is 1, the word shifts one place toward bit 0, the sign bit keeps its value, and the index becomes index plus 1 in ones-complement with end-around carry. When the flag is 0, AC and the index are unchanged.
- R8: Combined mode is selected when `op[1]`=1. The shifted word is AC bits 23..0 above BR bits 22..0, with AC bit 23 as the sign. At the end of every combined operation, BR bit 23 takes the final AC bit 23, including a right normalize with the flag at 0. In AC-only mode, BR is never changed.
- R9: For a left normalize of n steps, `done` is a one-clock pulse raised by the (n+2)-th rising edge, counting the edge that captured `start` as the first. For every other operation, including the no-op, it is raised by the second edge. The outputs hold their final values while `done` is high.
- R10: A `start` that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-clock strobe that launches an operation |
| op | input | 2 | bit0: 0 = left, 1 = right; bit1: 1 = combined AC:BR word |
| xSel | input | 3 | Index register number; 6 and 7 disable the operation |
| ovfFlag | input | 1 | Overflow flag, gates the right normalize |
| acIn | input | 24 | AC value to work on |
| brIn | input | 24 | BR value to work on |
| xrIn | input | 16 | Value of the selected index register |
| acOut | output | 24 | Resulting AC |
| brOut | output | 24 | Resulting BR |
| xrOut | output | 16 | Resulting index value |
| done | output | 1 | One-clock completion pulse |

## Verification
An off-by-one in the step counter or in the limit compare shows up twice at once when `done` rises. The latency is one cycle off, and the index result is one off. The all-zero and all-ones words expose this, because they run to the limit. A wrong bit fed into the low end, or a wrong bit at the AC/BR boundary, shows in `acOut` or `brOut` in that same `done` cycle. The negative vectors and the vectors whose set bit crosses the boundary drive both cases. A missing end-around carry shows only in the index, so some vectors start from 16'hFFFF or give zero-step results to bring it out.

// File: rtl/nrm_pkg.sv
package nrm_pkg;

  // Strobes issued by the sequencer to the datapath, one cycle each.
  typedef struct packed {
    logic load;
    logic shiftL;
    logic shiftR;
    logic incXr;
    logic subXr;
    logic copySign;
  } nrmStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } nrmState_t;

endpackage

// File: rtl/nrm_ctrl.sv
module nrm_ctrl
  import nrm_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int SEL_W = 3,
  localparam int WIDE_W = 2 * ACC_W - 1,
  localparam int CNT_W = $clog2(WIDE_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [SEL_W-1:0] xSel,
  input  logic             ovfFlag,
  input  logic             signEq,
  output nrmStrobes_t      strb,
  output logic             wideMode,
  output logic [CNT_W-1:0] shiftCount,
  output logic             done
);

  localparam logic [CNT_W-1:0] CAP_AC   = CNT_W'(ACC_W - 1);
  localparam logic [CNT_W-1:0] CAP_WIDE = CNT_W'(WIDE_W - 1);
  localparam logic [SEL_W-1:0] SEL_OFF  = SEL_W'(6);

  nrmState_t state;
  logic rightQ, offQ, ovfQ, finish;
  logic [CNT_W-1:0] capSel;

  assign capSel = wideMode ? CAP_WIDE : CAP_AC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      rightQ     <= 1'b0;
      wideMode   <= 1'b0;
      offQ       <= 1'b0;
      ovfQ       <= 1'b0;
      shiftCount <= '0;
      done       <= 1'b0;
    end else begin
      done <= finish;
      if (strb.load) begin
        state      <= ST_RUN;
        rightQ     <= op[0];
        wideMode   <= op[1];
        offQ       <= (xSel >= SEL_OFF);
        ovfQ       <= ovfFlag;
        shiftCount <= '0;
      end else if (state == ST_RUN) begin
        if (strb.shiftL) shiftCount <= shiftCount + 1'b1;
        if (finish) state <= ST_IDLE;
      end
    end
  end

  always_comb begin
    strb      = '0;
    finish    = 1'b0;
    strb.load = (state == ST_IDLE) && start;
    if (state == ST_RUN) begin
      if (offQ) begin
        finish = 1'b1;
      end else if (rightQ) begin
        strb.shiftR   = ovfQ;
        strb.incXr    = ovfQ;
        strb.copySign = wideMode;
        finish        = 1'b1;
      end else if (!signEq || shiftCount == capSel) begin
        strb.subXr    = 1'b1;
        strb.copySign = wideMode;
        finish        = 1'b1;
      end else begin
        strb.shiftL = 1'b1;
      end
    end
  end

  always_comb begin
    assert ($onehot0({strb.load, strb.shiftL, strb.shiftR}));
  end

  // R5
  step_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftCount <= capSel);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !finish) |=> $stable(wideMode) && $stable(rightQ));

endmodule

// File: rtl/nrm_datapath.sv
module nrm_datapath
  import nrm_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int XR_W  = 16,
  localparam int WIDE_W = 2 * ACC_W - 1,
  localparam int CNT_W = $clog2(WIDE_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  nrmStrobes_t      strb,
  input  logic             wideMode,
  input  logic [CNT_W-1:0] shiftCount,
  input  logic [ACC_W-1:0] acIn,
  input  logic [ACC_W-1:0] brIn,
  input  logic [XR_W-1:0]  xrIn,
  output logic [ACC_W-1:0] acQ,
  output logic [ACC_W-1:0] brQ,
  output logic [XR_W-1:0]  xrQ,
  output logic             signEq
);

  logic [WIDE_W-1:0] wide, wideL, wideR;
  logic [ACC_W-1:0]  acL, acR, acN, brN;
  logic [XR_W-1:0]   addend, xrRes, xrN;
  logic [XR_W:0]     rawSum;

  assign wide   = {acQ, brQ[ACC_W-2:0]};
  assign wideL  = {wide[WIDE_W-1], wide[WIDE_W-3:0], wide[WIDE_W-1]};
  assign wideR  = {wide[WIDE_W-1], wide[WIDE_W-1:1]};
  assign acL    = {acQ[ACC_W-1], acQ[ACC_W-3:0], acQ[ACC_W-1]};
  assign acR    = {acQ[ACC_W-1], acQ[ACC_W-1:1]};
  assign signEq = (acQ[ACC_W-1] == acQ[ACC_W-2]);

  // Ones-complement adder with end-around carry.
  assign addend = strb.incXr ? XR_W'(1) : ~XR_W'(shiftCount);
  assign rawSum = {1'b0, xrQ} + {1'b0, addend};
  assign xrRes  = rawSum[XR_W-1:0] + XR_W'(rawSum[XR_W]);

  always_comb begin
    acN = acQ;
    brN = brQ;
    xrN = xrQ;
    if (strb.load) begin
      acN = acIn;
      brN = brIn;
      xrN = xrIn;
    end else begin
      if (strb.shiftL) begin
        if (wideMode) {acN, brN[ACC_W-2:0]} = wideL;
        else acN = acL;
      end else if (strb.shiftR) begin
        if (wideMode) {acN, brN[ACC_W-2:0]} = wideR;
        else acN = acR;
      end
      if (strb.copySign) brN[ACC_W-1] = acN[ACC_W-1];
      if (strb.incXr || strb.subXr) xrN = xrRes;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acQ <= '0;
      brQ <= '0;
      xrQ <= '0;
    end else begin
      acQ <= acN;
      brQ <= brN;
      xrQ <= xrN;
    end
  end

  // R4
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftL || strb.shiftR) |=> acQ[ACC_W-1] == $past(acQ[ACC_W-1]));

  // R7
  right_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftR && !wideMode) |=> acQ[ACC_W-2:0] == $past(acQ[ACC_W-1:1]));

  // R8
  br_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.copySign |=> brQ[ACC_W-1] == acQ[ACC_W-1]);

  // R6
  xr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load || strb.incXr || strb.subXr) |=> $stable(xrQ));

endmodule

// File: rtl/acc_normalizer.sv
module acc_normalizer
  import nrm_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int XR_W  = 16,
  parameter int SEL_W = 3,
  localparam int WIDE_W = 2 * ACC_W - 1,
  localparam int CNT_W = $clog2(WIDE_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [SEL_W-1:0] xSel,
  input  logic             ovfFlag,
  input  logic [ACC_W-1:0] acIn,
  input  logic [ACC_W-1:0] brIn,
  input  logic [XR_W-1:0]  xrIn,
  output logic [ACC_W-1:0] acOut,
  output logic [ACC_W-1:0] brOut,
  output logic [XR_W-1:0]  xrOut,
  output logic             done
);

  nrmStrobes_t      strb;
  logic             wideMode, signEq;
  logic [CNT_W-1:0] shiftCount;

  nrm_ctrl #(.ACC_W(ACC_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .xSel(xSel),
    .ovfFlag(ovfFlag), .signEq(signEq), .strb(strb), .wideMode(wideMode),
    .shiftCount(shiftCount), .done(done)
  );

  nrm_datapath #(.ACC_W(ACC_W), .XR_W(XR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wideMode(wideMode),
    .shiftCount(shiftCount), .acIn(acIn), .brIn(brIn), .xrIn(xrIn),
    .acQ(acOut), .brQ(brOut), .xrQ(xrOut), .signEq(signEq)
  );

endmodule

// File: tb/test_acc_normalizer.sv
module test_acc_normalizer;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  xs;
    logic        ov;
    logic [23:0] ac;
    logic [23:0] br;
    logic [15:0] xr;
    logic [23:0] eAc;
    logic [23:0] eBr;
    logic [15:0] eXr;
    logic [7:0]  eLat;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd1, 1'b0, 24'h000001, 24'h123456, 16'h0030, 24'h400000, 24'h123456, 16'h001A, 8'd23},
    '{2'd0, 3'd2, 1'b0, 24'h400000, 24'h000000, 16'h0005, 24'h400000, 24'h000000, 16'h0005, 8'd1},
    '{2'd0, 3'd3, 1'b1, 24'hFFFFF0, 24'hABCDEF, 16'h0000, 24'h87FFFF, 24'hABCDEF, 16'hFFEC, 8'd20},
    '{2'd0, 3'd0, 1'b0, 24'h000000, 24'h000000, 16'h0100, 24'h000000, 24'h000000, 16'h00E9, 8'd24},
    '{2'd0, 3'd4, 1'b0, 24'hFFFFFF, 24'h000000, 16'h0020, 24'hFFFFFF, 24'h000000, 16'h0009, 8'd24},
    '{2'd2, 3'd5, 1'b0, 24'h000000, 24'h800001, 16'h0040, 24'h400000, 24'h000000, 16'h0013, 8'd46},
    '{2'd2, 3'd0, 1'b0, 24'h000000, 24'h800000, 16'h0100, 24'h000000, 24'h000000, 16'h00D2, 8'd47},
    '{2'd2, 3'd1, 1'b0, 24'hA00000, 24'h012345, 16'h0007, 24'hA00000, 24'h812345, 16'h0007, 8'd1},
    '{2'd2, 3'd2, 1'b0, 24'h000000, 24'h400000, 16'h0030, 24'h400000, 24'h000000, 16'h0019, 8'd24},
    '{2'd1, 3'd3, 1'b1, 24'h400001, 24'h111111, 16'h0003, 24'h200000, 24'h111111, 16'h0004, 8'd1},
    '{2'd1, 3'd4, 1'b1, 24'h800003, 24'h000000, 16'hFFFF, 24'hC00001, 24'h000000, 16'h0001, 8'd1},
    '{2'd1, 3'd5, 1'b0, 24'h123456, 24'h000000, 16'h0009, 24'h123456, 24'h000000, 16'h0009, 8'd1},
    '{2'd3, 3'd0, 1'b1, 24'h000001, 24'h800000, 16'h0010, 24'h000000, 24'h400000, 16'h0011, 8'd1},
    '{2'd3, 3'd1, 1'b0, 24'h800000, 24'h000005, 16'h0022, 24'h800000, 24'h800005, 16'h0022, 8'd1},
    '{2'd0, 3'd6, 1'b0, 24'h000001, 24'h000000, 16'h1234, 24'h000001, 24'h000000, 16'h1234, 8'd1},
    '{2'd3, 3'd7, 1'b1, 24'h000002, 24'h800000, 16'h0050, 24'h000002, 24'h800000, 16'h0050, 8'd1},
    '{2'd3, 3'd2, 1'b1, 24'hFFFFFE, 24'h000003, 16'h7FFF, 24'hFFFFFF, 24'h800001, 16'h8000, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [2:0]  xSel = '0;
  logic        ovfFlag = 1'b0;
  logic [23:0] acIn = '0, brIn = '0;
  logic [15:0] xrIn = '0;
  logic [23:0] acOut, brOut;
  logic [15:0] xrOut;
  logic        done;

  int nChecks = 0;
  int nFails = 0;
  int lat;

  acc_normalizer i_acc_normalizer (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .xSel(xSel),
    .ovfFlag(ovfFlag), .acIn(acIn), .brIn(brIn), .xrIn(xrIn),
    .acOut(acOut), .brOut(brOut), .xrOut(xrOut), .done(done)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    op = v.op; xSel = v.xs; ovfFlag = v.ov;
    acIn = v.ac; brIn = v.br; xrIn = v.xr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // scramble inputs after capture (R2)
    op = ~v.op; xSel = 3'd0; ovfFlag = ~v.ov;
    acIn = 24'h5A5A5A; brIn = 24'hA5A5A5; xrIn = 16'h3C3C;
  endtask

  task automatic waitDone();
    lat = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      lat++;
      if (done) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    vec_t b1, b2;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 done", 32'(done), 0);
    check("R1 acOut", 32'(acOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 done after release", 32'(done), 0);
    check("R1 brOut", 32'(brOut), 0);
    check("R1 xrOut", 32'(xrOut), 0);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      string tAc, tXr, tBr;
      v = VECS[k];
      launch(v);
      waitDone();
      if (v.xs >= 3'd6) begin
        tAc = "R3 ac"; tXr = "R3 xr"; tBr = "R3 br";
      end else begin
        tAc = v.op[0] ? "R7 ac" : (v.eLat >= 8'd24 ? "R5 ac" : "R4 ac");
        tXr = v.op[0] ? "R7 xr" : "R6 xr";
        tBr = v.op[1] ? "R8 br" : "R8 br untouched";
      end
      check(tAc, 32'(acOut), 32'(v.eAc));
      check(tBr, 32'(brOut), 32'(v.eBr));
      check(tXr, 32'(xrOut), 32'(v.eXr));
      check("R9 latency", 32'(lat), 32'(v.eLat));
      @(negedge clk);
      check("R9 pulse width", 32'(done), 0);
      check("R2 hold after done", 32'(acOut), 32'(v.eAc));
    end

    // R10 start during a long run is ignored
    b1 = VECS[3];
    b2 = VECS[9];
    launch(b1);
    repeat (4) @(negedge clk);
    op = b2.op; xSel = b2.xs; ovfFlag = b2.ov;
    acIn = b2.ac; brIn = b2.br; xrIn = b2.xr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 5;
    for (int i = 0; i < 200; i++) begin
      if (done) break;
      @(negedge clk);
      lat++;
    end
    check("R10 ac", 32'(acOut), 32'(b1.eAc));
    check("R10 xr", 32'(xrOut), 32'(b1.eXr));
    check("R10 latency", 32'(lat), 32'(b1.eLat));
    @(negedge clk);
    check("R10 no second done", 32'(done), 0);

    // R2 inputs sampled only at start: next op sees captured values
    launch(VECS[12]);
    waitDone();
    check("R2 captured ac", 32'(acOut), 32'(VECS[12].eAc));
    check("R2 captured br", 32'(brOut), 32'(VECS[12].eBr));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule